// File: doc/BRIEF.md
# Path-Indexed Indirect Branch Target Predictor

This block predicts where an indirect jump or call will go when that branch has more than one destination. It holds a direct-mapped table of targets. The table is addressed by mixing bits of the branch address with a snapshot of recent global branch outcomes. Because the path leading to a branch is part of the index, one branch can keep several targets at once, and each target is picked by the history that precedes it.

A front end presents a branch address and its history snapshot on the lookup port. One cycle later the block reports a hit and a predicted target. On a miss the caller uses its ordinary single-target buffer. When the branch retires, the resolve port carries the same address and history, the actual target, and a flag that says whether the earlier prediction was wrong. The block writes an entry only when that flag is set, so branches that are already predicted well never displace useful entries.

Top module: `ibp_indirect_pred`

## Requirements
- R1: After an asynchronous reset every entry is invalid, and every lookup misses until a mispredicting resolve has written an entry.
- R2: rsp_valid_o is high in exactly the cycle after a cycle in which lkp_valid_i was high, and low otherwise.
- R3: A response hits only when the addressed entry is valid and its stored 8-bit tag equals bits [18:11] of the lookup address. On a hit rsp_target_o carries the stored target.
- R4: When rsp_hit_o is low, rsp_target_o is zero.
- R5: A resolve with upd_valid_i and upd_mispredict_i both high writes the entry at its index with its tag and target. A later lookup with the same address and history hits and returns that target.
- R6: A resolve with upd_mispredict_i low writes nothing, and later lookups of that address and history still miss.
- R7: The 9-bit index is address bits [10:2] XOR a fold of the 12-bit history. The fold is history[8:0] with history[11:9] XORed into bits [2:0]. The same address under different folded histories uses different entries, and histories that fold to equal values share an entry.
- R8: A lookup whose index matches a valid entry but whose tag differs misses.
- R9: If a write and a lookup address the same entry in the same cycle, the response shows the entry as it was before the write.
- R10: A mispredicting resolve overwrites an occupied entry, and it replaces both the tag and the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_pc_i | input | 32 | Address of the branch being looked up |
| lkp_hist_i | input | 12 | Global history snapshot for the lookup |
| rsp_valid_o | output | 1 | Lookup response present |
| rsp_hit_o | output | 1 | Response found a matching entry |
| rsp_target_o | output | 32 | Predicted target, zero on a miss |
| upd_valid_i | input | 1 | Resolve report present |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_hist_i | input | 12 | History snapshot used when that branch was predicted |
| upd_target_i | input | 32 | Actual target |
| upd_mispredict_i | input | 1 | The earlier prediction was wrong, so allocate |

## Verification
A lookup is captured at one rising edge, and its hit and target are valid until the next rising edge. A resolve write is captured at a rising edge, so the earliest lookup that can see it is the one captured at the following edge. The bench drives inputs on the falling edge, lets one rising edge pass, removes the request, and samples the response at the next falling edge. This places each check inside the single cycle in which the result is due. The same-cycle collision test drives the lookup and the write together and reads the old value in that window. It then issues a second lookup and reads the new value one cycle later.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
  localparam int unsigned IBP_ADDR_W = 32;
  localparam int unsigned IBP_TGT_W  = 32;
  localparam int unsigned IBP_HIST_W = 12;
  localparam int unsigned IBP_IDX_W  = 9;
  localparam int unsigned IBP_TAG_W  = 8;
  localparam int unsigned IBP_PC_LSB = 2;
endpackage

// File: rtl/ibp_hash.sv
module ibp_hash #(
  parameter int unsigned ADDR_W = ibp_pkg::IBP_ADDR_W,
  parameter int unsigned HIST_W = ibp_pkg::IBP_HIST_W,
  parameter int unsigned IDX_W  = ibp_pkg::IBP_IDX_W,
  parameter int unsigned TAG_W  = ibp_pkg::IBP_TAG_W,
  parameter int unsigned PC_LSB = ibp_pkg::IBP_PC_LSB
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [HIST_W-1:0] hist_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int unsigned TAG_LSB = PC_LSB + IDX_W;
  localparam int unsigned USED_HI = TAG_LSB + TAG_W;

  logic [IDX_W-1:0] hist_fold;

  // wrap history bits above IDX_W back onto the low index bits
  always_comb begin
    hist_fold = '0;
    for (int j = 0; j < int'(HIST_W); j++) begin
      hist_fold[j % IDX_W] = hist_fold[j % IDX_W] ^ hist_i[j];
    end
  end

  assign idx_o = pc_i[PC_LSB +: IDX_W] ^ hist_fold;
  assign tag_o = pc_i[TAG_LSB +: TAG_W];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc_i[ADDR_W-1:USED_HI], pc_i[PC_LSB-1:0]};
endmodule

// File: rtl/ibp_table.sv
module ibp_table #(
  parameter int unsigned IDX_W = ibp_pkg::IBP_IDX_W,
  parameter int unsigned TAG_W = ibp_pkg::IBP_TAG_W,
  parameter int unsigned TGT_W = ibp_pkg::IBP_TGT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [TGT_W-1:0] rd_tgt_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [TGT_W-1:0] wr_tgt_i
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [TGT_W-1:0]   tgt_mem [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_mem[wr_idx_i] <= wr_tag_i;
      tgt_mem[wr_idx_i] <= wr_tgt_i;
    end
  end

  // read registers sample pre-write contents on a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
    end else if (rd_en_i) begin
      rd_valid_o <= valid_q[rd_idx_i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rd_en_i) begin
      rd_tag_o <= tag_mem[rd_idx_i];
      rd_tgt_o <= tgt_mem[rd_idx_i];
    end
  end
endmodule

// File: rtl/ibp_indirect_pred.sv
module ibp_indirect_pred #(
  parameter int unsigned ADDR_W = ibp_pkg::IBP_ADDR_W,
  parameter int unsigned TGT_W  = ibp_pkg::IBP_TGT_W,
  parameter int unsigned HIST_W = ibp_pkg::IBP_HIST_W,
  parameter int unsigned IDX_W  = ibp_pkg::IBP_IDX_W,
  parameter int unsigned TAG_W  = ibp_pkg::IBP_TAG_W,
  parameter int unsigned PC_LSB = ibp_pkg::IBP_PC_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [ADDR_W-1:0] lkp_pc_i,
  input  logic [HIST_W-1:0] lkp_hist_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [TGT_W-1:0]  rsp_target_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic [HIST_W-1:0] upd_hist_i,
  input  logic [TGT_W-1:0]  upd_target_i,
  input  logic              upd_mispredict_i
);
  localparam int unsigned NPORT = 2;
  localparam int unsigned P_LKP = 0;
  localparam int unsigned P_UPD = 1;

  logic [ADDR_W-1:0] port_pc   [NPORT];
  logic [HIST_W-1:0] port_hist [NPORT];
  logic [IDX_W-1:0]  port_idx  [NPORT];
  logic [TAG_W-1:0]  port_tag  [NPORT];

  assign port_pc[P_LKP]   = lkp_pc_i;
  assign port_hist[P_LKP] = lkp_hist_i;
  assign port_pc[P_UPD]   = upd_pc_i;
  assign port_hist[P_UPD] = upd_hist_i;

  for (genvar p = 0; p < int'(NPORT); p++) begin : g_hash
    ibp_hash #(
      .ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(IDX_W),
      .TAG_W(TAG_W), .PC_LSB(PC_LSB)
    ) u_hash (
      .pc_i  (port_pc[p]),
      .hist_i(port_hist[p]),
      .idx_o (port_idx[p]),
      .tag_o (port_tag[p])
    );
  end

  logic             alloc;
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [TGT_W-1:0] rd_tgt;
  logic [TAG_W-1:0] lkp_tag_q;
  logic             rsp_valid_q;

  assign alloc = upd_valid_i & upd_mispredict_i;

  ibp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (lkp_valid_i),
    .rd_idx_i  (port_idx[P_LKP]),
    .rd_valid_o(rd_valid),
    .rd_tag_o  (rd_tag),
    .rd_tgt_o  (rd_tgt),
    .wr_en_i   (alloc),
    .wr_idx_i  (port_idx[P_UPD]),
    .wr_tag_i  (port_tag[P_UPD]),
    .wr_tgt_i  (upd_target_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      lkp_tag_q   <= '0;
    end else begin
      rsp_valid_q <= lkp_valid_i;
      if (lkp_valid_i) lkp_tag_q <= port_tag[P_LKP];
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_hit_o    = rsp_valid_q & rd_valid & (rd_tag == lkp_tag_q);
  assign rsp_target_o = rsp_hit_o ? rd_tgt : '0;
endmodule

// File: rtl/ibp_checker.sv
module ibp_checker #(
  parameter int unsigned TGT_W = ibp_pkg::IBP_TGT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lkp_valid_i,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic [TGT_W-1:0] rsp_target_o,
  input logic             upd_valid_i,
  input logic             upd_mispredict_i
);
  logic alloc_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alloc_seen_q <= 1'b0;
    else if (upd_valid_i && upd_mispredict_i) alloc_seen_q <= 1'b1;
  end

  AST_RSP_AFTER_LKP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> rsp_valid_o); // R2
  AST_NO_RSP_WITHOUT_LKP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> !rsp_valid_o); // R2
  AST_HIT_IMPLIES_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o); // R3
  AST_MISS_TGT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_hit_o |-> rsp_target_o == '0); // R4
  AST_NO_HIT_BEFORE_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> alloc_seen_q); // R1
endmodule

bind ibp_indirect_pred ibp_checker #(.TGT_W(TGT_W)) u_ibp_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .lkp_valid_i     (lkp_valid_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_hit_o       (rsp_hit_o),
  .rsp_target_o    (rsp_target_o),
  .upd_valid_i     (upd_valid_i),
  .upd_mispredict_i(upd_mispredict_i)
);

// File: tb/ibp_indirect_pred_bench.sv
module ibp_indirect_pred_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_pc = '0;
  logic [11:0] lkp_hist = '0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [31:0] rsp_target;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [11:0] upd_hist = '0;
  logic [31:0] upd_target = '0;
  logic        upd_misp = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  ibp_indirect_pred u_ibp_indirect_pred (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_pc_i(lkp_pc), .lkp_hist_i(lkp_hist),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_target_o(rsp_target),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_hist_i(upd_hist),
    .upd_target_i(upd_target), .upd_mispredict_i(upd_misp)
  );

  typedef struct packed {
    logic        upd;
    logic [31:0] pc;
    logic [11:0] hist;
    logic [31:0] tgt;
    logic        misp;
    logic        exp_hit;
    logic [31:0] exp_tgt;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 32'h1000, 12'h000, 32'h0,        1'b0, 1'b0, 32'h0,        4'd1},  // R1 empty
    '{1'b1, 32'h1000, 12'h000, 32'hAAAA0000, 1'b1, 1'b0, 32'h0,        4'd5},
    '{1'b0, 32'h1000, 12'h000, 32'h0,        1'b0, 1'b1, 32'hAAAA0000, 4'd5},  // R5
    '{1'b0, 32'h1000, 12'h001, 32'h0,        1'b0, 1'b0, 32'h0,        4'd7},  // R7 new path
    '{1'b1, 32'h1000, 12'h001, 32'hBBBB0000, 1'b1, 1'b0, 32'h0,        4'd7},
    '{1'b0, 32'h1000, 12'h001, 32'h0,        1'b0, 1'b1, 32'hBBBB0000, 4'd7},  // R7
    '{1'b0, 32'h1000, 12'h000, 32'h0,        1'b0, 1'b1, 32'hAAAA0000, 4'd3},  // R3
    '{1'b0, 32'h1000, 12'h201, 32'h0,        1'b0, 1'b1, 32'hAAAA0000, 4'd7},  // R7 fold
    '{1'b1, 32'h1008, 12'h000, 32'h00000001, 1'b0, 1'b0, 32'h0,        4'd6},
    '{1'b0, 32'h1008, 12'h000, 32'h0,        1'b0, 1'b0, 32'h0,        4'd6},  // R6
    '{1'b0, 32'h1800, 12'h000, 32'h0,        1'b0, 1'b0, 32'h0,        4'd8},  // R8 alias
    '{1'b1, 32'h1800, 12'h000, 32'hCCCC0000, 1'b1, 1'b0, 32'h0,        4'd10},
    '{1'b0, 32'h1800, 12'h000, 32'h0,        1'b0, 1'b1, 32'hCCCC0000, 4'd10}, // R10
    '{1'b0, 32'h1000, 12'h000, 32'h0,        1'b0, 1'b0, 32'h0,        4'd10}, // R10 evicted
    '{1'b0, 32'h1008, 12'h000, 32'h0,        1'b0, 1'b0, 32'h0,        4'd4}   // R4
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    lkp_valid = 1'b0; upd_valid = 1'b0; upd_misp = 1'b0;
  endtask

  task automatic lookup_check(input logic [31:0] pc, input logic [11:0] hist,
                              input logic hit, input logic [31:0] tgt, input string req);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_pc = pc; lkp_hist = hist;
    @(negedge clk);
    idle();
    check(req, {29'd0, rsp_valid, rsp_hit, 1'b0}, {29'd0, 1'b1, hit, 1'b0});
    check(req, rsp_target, tgt);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in and right after reset
    check("R1", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {30'd0, rsp_valid, rsp_hit}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      if (VEC[i].upd) begin
        upd_valid = 1'b1; upd_pc = VEC[i].pc; upd_hist = VEC[i].hist;
        upd_target = VEC[i].tgt; upd_misp = VEC[i].misp;
      end else begin
        lkp_valid = 1'b1; lkp_pc = VEC[i].pc; lkp_hist = VEC[i].hist;
      end
      @(negedge clk);
      idle();
      if (!VEC[i].upd) begin
        check(req_name(VEC[i].req), {30'd0, rsp_valid, rsp_hit}, {30'd0, 1'b1, VEC[i].exp_hit});
        check(req_name(VEC[i].req), rsp_target, VEC[i].exp_tgt);
      end
    end

    // R2: response lasts one cycle only
    @(negedge clk);
    lkp_valid = 1'b1; lkp_pc = 32'h1800; lkp_hist = '0;
    @(negedge clk);
    idle();
    check("R2", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    check("R2", {31'd0, rsp_valid}, 32'd0);

    // R9: collision returns old contents (index 0 holds tag 3 -> miss for tag 4)
    @(negedge clk);
    lkp_valid = 1'b1; lkp_pc = 32'h2000; lkp_hist = '0;
    upd_valid = 1'b1; upd_pc = 32'h2000; upd_hist = '0;
    upd_target = 32'hDDDD0000; upd_misp = 1'b1;
    @(negedge clk);
    idle();
    check("R9", {31'd0, rsp_hit}, 32'd0);
    lookup_check(32'h2000, 12'h000, 1'b1, 32'hDDDD0000, "R9");

    // R9: collision on a hit returns old target
    @(negedge clk);
    lkp_valid = 1'b1; lkp_pc = 32'h2000; lkp_hist = '0;
    upd_valid = 1'b1; upd_pc = 32'h2000; upd_hist = '0;
    upd_target = 32'hEEEE0000; upd_misp = 1'b1;
    @(negedge clk);
    idle();
    check("R9", rsp_target, 32'hDDDD0000);
    lookup_check(32'h2000, 12'h000, 1'b1, 32'hEEEE0000, "R10");

    // R1: reset invalidates a populated table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lookup_check(32'h2000, 12'h000, 1'b0, 32'h0, "R1");

    finish_run();
  end
endmodule